// File: doc/BRIEF.md
# Multi-I/O Serial Flash Fast-Read Engine

This block sits on the host side of a serial flash and turns one read request into a complete fast-read transaction on the flash pins. It supports three read widths. In single-line mode, data returns on one line. In dual-output mode, data returns two bits per clock. In quad mode, the address, the mode byte and the data all travel four bits per clock. For each width the engine selects the opcode, serialises the 24-bit address at the matching width and inserts that mode's dummy clocks. It releases the data lines before the flash starts driving them. It then packs the returned bits into bytes, most significant bit first.

Requests arrive on a valid/ready stream. A request is taken only while the engine is idle, and it carries the start address, the read width, a byte count and an optional wrap window of 8, 16, 32 or 64 bytes. Bytes leave on a second valid/ready stream. A byte that is offered stays on the stream with its value unchanged until it is taken. When the consumer holds ready low, the engine does not drop data. It holds the serial clock low, which the flash tolerates, until the held byte is taken. The last byte of a request is flagged.

When a wrap window is selected, the byte addresses run upward inside the aligned window and then return to the window start. The flash itself reads linearly, so at each window end that is not the end of the request the engine deselects the flash and issues a new read at the window base.

Top module: `ffr_fast_read`

## Requirements
- R1: After reset, `fl_cs_n` is 1, `fl_sck` is 0, `fl_io_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: `req_mode` value 0 selects single-line mode, and so does the unused value 3. The engine sends opcode 0Bh and then the 24 address bits on IO0, most significant bit first. It then gives 8 dummy clocks. Data bits arrive on IO1, one per clock, bit 7 first.
- R3: `req_mode` value 1 selects dual-output mode. The engine sends opcode 3Bh and the address on IO0, then gives 4 dummy clocks. Data arrives two bits per clock, with IO1 carrying the higher bit, so bits 7:6 arrive first.
- R4: `req_mode` value 2 selects quad mode. The engine sends opcode EBh on IO0. It then sends the address four bits per clock, with IO3 carrying the highest bit. Next come 2 mode clocks on which all four lines are driven to 0, then 4 dummy clocks. Data arrives as nibbles on IO3..IO0, upper nibble first.
- R5: During the dummy and data clocks, the engine drives none of the lines the flash may drive. In quad mode that is all four lines. In the other modes it is IO0 and IO1.
- R6: While the flash is selected, IO2 and IO3 are driven to 1 during the opcode in every mode. In single-line and dual-output modes they stay driven to 1 for the whole transaction.
- R7: Without wrap, byte `i` of a request comes from address (start + i) mod 2^24.
- R8: With wrap, `req_wsel` values 0, 1, 2 and 3 select windows of 8, 16, 32 and 64 bytes. Each next address is the window base plus (address + 1) mod the window size. When the window end is reached and more bytes remain, the flash is deselected and a new read starts at the window base.
- R9: A byte that is offered on `rd_valid` keeps `rd_data` and `rd_last` unchanged until `rd_ready` is seen. Back-pressure stretches the serial clock and loses no byte. `rd_last` is 1 only on the final byte of a request.
- R10: A request with `req_len` equal to 0 is accepted and causes no flash selection and no output byte.
- R11: Requests are accepted only while `fl_cs_n` is 1. Each high level of `fl_sck` lasts one `clk` cycle, and `fl_sck` is 0 whenever `fl_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Engine idle and taking a request |
| req_addr | input | 24 | Start byte address |
| req_mode | input | 2 | Read width: 0 single, 1 dual, 2 quad, 3 single |
| req_len | input | 16 | Number of bytes to read; 0 does nothing |
| req_wrap | input | 1 | Enable aligned wrap window |
| req_wsel | input | 2 | Window size: 8 << req_wsel bytes |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Consumer takes the offered byte |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Final byte of the request |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck | output | 1 | Flash serial clock, clk/2 while running |
| fl_io_out | output | 4 | Values driven on IO3..IO0 |
| fl_io_oe | output | 4 | Drive enables for IO3..IO0 |
| fl_io_in | input | 4 | Values sensed on IO3..IO0 |

## Verification
The hardest case to reach from the ports is a window end that falls on a byte the consumer is still holding back. In that case the clock stretch, the deselect and the re-issue at the window base must all happen in the right order, with no byte lost or repeated. The bench drives `rd_ready` from a shift-register pattern and starts wrap reads a few bytes before a window end, in every width and window size, so that stalls land on and near the re-issue point. A flash model in the bench answers only after the exact dummy count of each mode. It also reports any clock on which it and the engine drive the same line.

// File: rtl/ffr_pkg.sv
package ffr_pkg;

  typedef enum logic [1:0] {
    RM_SINGLE = 2'd0,
    RM_DUAL   = 2'd1,
    RM_QUAD   = 2'd2,
    RM_RSVD   = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CMD,
    SQ_ADDR,
    SQ_MODE,
    SQ_DUMMY,
    SQ_DATA,
    SQ_GAP
  } seq_e;

  function automatic logic [7:0] op_code(rd_mode_e m);
    case (m)
      RM_DUAL: return 8'h3B;
      RM_QUAD: return 8'hEB;
      default: return 8'h0B;
    endcase
  endfunction

  function automatic rd_mode_e norm_mode(logic [1:0] raw);
    case (raw)
      2'd1:    return RM_DUAL;
      2'd2:    return RM_QUAD;
      default: return RM_SINGLE;
    endcase
  endfunction

endpackage

// File: rtl/ffr_addr_track.sv
module ffr_addr_track #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wrap_en,
  input  logic [1:0]        win_sel,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              win_end
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] addr_next;

  always_comb begin
    mask      = ADDR_W'((32'd8 << win_sel) - 32'd1);
    addr_inc  = addr_q + ADDR_W'(1);
    addr_next = wrap_en ? ((addr_q & ~mask) | (addr_inc & mask)) : addr_inc;
  end

  assign win_end = wrap_en && ((addr_q & mask) == mask);
  assign addr    = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_addr;
    else if (step) addr_q <= addr_next;
  end
endmodule

// File: rtl/ffr_rx_assemble.sv
module ffr_rx_assemble
  import ffr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     shift_en,
  input  rd_mode_e mode,
  input  logic [3:0] io_in,
  output logic [7:0] byte_next,
  output logic     last_slot
);
  logic [7:0] acc_q;
  logic [2:0] slot_q;

  always_comb begin
    case (mode)
      RM_QUAD: begin
        byte_next = {acc_q[3:0], io_in};
        last_slot = (slot_q == 3'd1);
      end
      RM_DUAL: begin
        byte_next = {acc_q[5:0], io_in[1], io_in[0]};
        last_slot = (slot_q == 3'd3);
      end
      default: begin
        byte_next = {acc_q[6:0], io_in[1]};
        last_slot = (slot_q == 3'd7);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
    end else if (clr) begin
      slot_q <= '0;
    end else if (shift_en) begin
      acc_q  <= byte_next;
      slot_q <= last_slot ? 3'd0 : slot_q + 3'd1;
    end
  end
endmodule

// File: rtl/ffr_fast_read.sv
module ffr_fast_read
  import ffr_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_W        = 16,
  parameter int DUMMY_SINGLE = 8,
  parameter int DUMMY_DUAL   = 4,
  parameter int DUMMY_QUAD   = 4,
  parameter int MODE_CLKS    = 2,
  parameter int GAP_CYC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_mode,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_wrap,
  input  logic [1:0]        req_wsel,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              rd_last,
  output logic              fl_cs_n,
  output logic              fl_sck,
  output logic [3:0]        fl_io_out,
  output logic [3:0]        fl_io_oe,
  input  logic [3:0]        fl_io_in
);
  localparam int TX_W    = ADDR_W + 8;
  localparam int CNT_MAX = ADDR_W + DUMMY_SINGLE + DUMMY_DUAL + DUMMY_QUAD + MODE_CLKS + GAP_CYC + 8;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_e              state_q;
  rd_mode_e          mode_q;
  rd_mode_e          req_mode_n;
  logic              ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  dummy_last;
  logic [TX_W-1:0]   txsr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              wrap_q;
  logic [1:0]        wsel_q;
  logic              again_q;
  logic              out_valid_q;
  logic [7:0]        out_data_q;
  logic              out_last_q;

  logic              accept;
  logic              shift_en;
  logic              last_slot;
  logic              byte_done;
  logic              stall;
  logic              turn_phase;
  logic              active;
  logic [7:0]        byte_next;
  logic [ADDR_W-1:0] cur_addr;
  logic              win_end;

  assign req_mode_n = norm_mode(req_mode);
  assign accept     = req_valid && (state_q == SQ_IDLE);
  assign shift_en   = (state_q == SQ_DATA) && ph_q;
  assign byte_done  = shift_en && last_slot;
  assign stall      = (state_q == SQ_DATA) && !ph_q && last_slot && out_valid_q && !rd_ready;
  assign turn_phase = (state_q == SQ_DUMMY) || (state_q == SQ_DATA);
  assign active     = (state_q != SQ_IDLE) && (state_q != SQ_GAP);

  ffr_addr_track #(.ADDR_W(ADDR_W)) addr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (req_addr),
    .wrap_en   (wrap_q),
    .win_sel   (wsel_q),
    .step      (byte_done),
    .addr      (cur_addr),
    .win_end   (win_end)
  );

  ffr_rx_assemble rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (state_q != SQ_DATA),
    .shift_en  (shift_en),
    .mode      (mode_q),
    .io_in     (fl_io_in),
    .byte_next (byte_next),
    .last_slot (last_slot)
  );

  always_comb begin
    case (mode_q)
      RM_DUAL: dummy_last = CNT_W'(DUMMY_DUAL - 1);
      RM_QUAD: dummy_last = CNT_W'(DUMMY_QUAD - 1);
      default: dummy_last = CNT_W'(DUMMY_SINGLE - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      mode_q      <= RM_SINGLE;
      ph_q        <= 1'b0;
      cnt_q       <= '0;
      txsr_q      <= '0;
      rem_q       <= '0;
      wrap_q      <= 1'b0;
      wsel_q      <= '0;
      again_q     <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_last_q  <= 1'b0;
    end else begin
      if (rd_ready) out_valid_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (accept && (req_len != '0)) begin
            mode_q  <= req_mode_n;
            rem_q   <= req_len;
            wrap_q  <= req_wrap;
            wsel_q  <= req_wsel;
            txsr_q  <= {op_code(req_mode_n), req_addr};
            cnt_q   <= CNT_W'(7);
            again_q <= 1'b0;
            state_q <= SQ_CMD;
          end
        end
        SQ_GAP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (again_q) begin
            txsr_q  <= {op_code(mode_q), cur_addr};
            cnt_q   <= CNT_W'(7);
            again_q <= 1'b0;
            state_q <= SQ_CMD;
          end else begin
            state_q <= SQ_IDLE;
          end
        end
        default: begin
          if (!ph_q) begin
            if (!stall) ph_q <= 1'b1;
          end else begin
            ph_q <= 1'b0;
            if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
            case (state_q)
              SQ_CMD: begin
                txsr_q <= {txsr_q[TX_W-2:0], 1'b0};
                if (cnt_q == '0) begin
                  state_q <= SQ_ADDR;
                  cnt_q   <= (mode_q == RM_QUAD) ? CNT_W'(ADDR_W/4 - 1) : CNT_W'(ADDR_W - 1);
                end
              end
              SQ_ADDR: begin
                if (mode_q == RM_QUAD) txsr_q <= {txsr_q[TX_W-5:0], 4'b0000};
                else                   txsr_q <= {txsr_q[TX_W-2:0], 1'b0};
                if (cnt_q == '0) begin
                  if (mode_q == RM_QUAD) begin
                    state_q <= SQ_MODE;
                    cnt_q   <= CNT_W'(MODE_CLKS - 1);
                  end else begin
                    state_q <= SQ_DUMMY;
                    cnt_q   <= dummy_last;
                  end
                end
              end
              SQ_MODE: begin
                if (cnt_q == '0) begin
                  state_q <= SQ_DUMMY;
                  cnt_q   <= dummy_last;
                end
              end
              SQ_DUMMY: begin
                if (cnt_q == '0) state_q <= SQ_DATA;
              end
              SQ_DATA: begin
                if (last_slot) begin
                  out_valid_q <= 1'b1;
                  out_data_q  <= byte_next;
                  out_last_q  <= (rem_q == LEN_W'(1));
                  rem_q       <= rem_q - LEN_W'(1);
                  if (rem_q == LEN_W'(1)) begin
                    state_q <= SQ_GAP;
                    again_q <= 1'b0;
                    cnt_q   <= CNT_W'(GAP_CYC - 1);
                  end else if (win_end) begin
                    state_q <= SQ_GAP;
                    again_q <= 1'b1;
                    cnt_q   <= CNT_W'(GAP_CYC - 1);
                  end
                end
              end
              default: state_q <= SQ_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    fl_io_out = 4'b0000;
    fl_io_oe  = 4'b0000;
    if (active) begin
      if ((mode_q != RM_QUAD) || (state_q == SQ_CMD)) begin
        fl_io_out[3:2] = 2'b11;
        fl_io_oe[3:2]  = 2'b11;
      end
      case (state_q)
        SQ_CMD: begin
          fl_io_out[0] = txsr_q[TX_W-1];
          fl_io_oe[0]  = 1'b1;
        end
        SQ_ADDR: begin
          if (mode_q == RM_QUAD) begin
            fl_io_out = txsr_q[TX_W-1 -: 4];
            fl_io_oe  = 4'b1111;
          end else begin
            fl_io_out[0] = txsr_q[TX_W-1];
            fl_io_oe[0]  = 1'b1;
          end
        end
        SQ_MODE: begin
          fl_io_out = 4'b0000;
          fl_io_oe  = 4'b1111;
        end
        default: ;
      endcase
    end
  end

  assign req_ready = (state_q == SQ_IDLE);
  assign fl_cs_n   = !active;
  assign fl_sck    = ph_q;
  assign rd_valid  = out_valid_q;
  assign rd_data   = out_data_q;
  assign rd_last   = out_last_q;

endmodule

// File: rtl/ffr_checker.sv
module ffr_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             rd_last,
  input logic             fl_cs_n,
  input logic             fl_sck,
  input logic [3:0]       fl_io_out,
  input logic [3:0]       fl_io_oe,
  input logic [1:0]       mode_q,
  input logic             turn_phase
);
  // R9: an offered byte stays put until taken
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last));

  // R11: one-cycle clock high, clock low while deselected, requests only while deselected
  a_r11_sck_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fl_sck |=> !fl_sck);
  a_r11_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sck);
  a_r11_take_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> fl_cs_n);

  // R5: lines the flash may drive are released in dummy and data clocks
  a_r5_low_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    turn_phase |-> (fl_io_oe[1:0] == 2'b00));
  a_r5_quad_all_free: assert property (@(posedge clk) disable iff (!rst_n)
    turn_phase && (mode_q == 2'd2) |-> (fl_io_oe == 4'b0000));

  // R6: protect and hold lines held inactive outside quad transfers
  a_r6_ctl_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_cs_n && (mode_q != 2'd2) |-> (fl_io_oe[3:2] == 2'b11) && (fl_io_out[3:2] == 2'b11));

  // R10: an empty request does not select the flash
  a_r10_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len == '0) |=> fl_cs_n);
endmodule

bind ffr_fast_read ffr_checker #(.LEN_W(LEN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_len    (req_len),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .rd_last    (rd_last),
  .fl_cs_n    (fl_cs_n),
  .fl_sck     (fl_sck),
  .fl_io_out  (fl_io_out),
  .fl_io_oe   (fl_io_oe),
  .mode_q     (mode_q),
  .turn_phase (turn_phase)
);

// File: tb/ffr_fast_read_tb_top.sv
`timescale 1ns/1ps
module ffr_fast_read_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_mode = '0;
  logic [15:0] req_len = '0;
  logic        req_wrap = 1'b0;
  logic [1:0]  req_wsel = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        rd_last;
  logic        fl_cs_n;
  logic        fl_sck;
  logic [3:0]  fl_io_out;
  logic [3:0]  fl_io_oe;
  logic [3:0]  fl_io_in;

  always #4 clk = ~clk;

  ffr_fast_read dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_mode(req_mode), .req_len(req_len), .req_wrap(req_wrap), .req_wsel(req_wsel),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .fl_cs_n(fl_cs_n), .fl_sck(fl_sck), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
    .fl_io_in(fl_io_in)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  string cur_tag = "";
  logic [8:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // ---------------- flash model ----------------
  int          mclk = 0;
  int          txn_cnt = 0;
  logic [7:0]  mcmd = '0;
  logic [7:0]  last_cmd = '0;
  logic [23:0] maddr = '0;
  logic [3:0]  m_drv = '0;
  logic [3:0]  m_oe = '0;
  int          io23_err = 0;
  int          clash_err = 0;
  int          busy_err = 0;
  int          hold_err = 0;

  assign fl_io_in = m_drv & m_oe;

  always @(negedge fl_cs_n) begin
    mclk = 0; mcmd = '0; maddr = '0; m_oe = '0;
    txn_cnt++;
  end
  always @(posedge fl_cs_n) m_oe = '0;

  always @(posedge fl_sck) begin
    if (!fl_cs_n) begin
      if (!(mclk >= 8 && mcmd == 8'hEB))
        if (fl_io_oe[3:2] != 2'b11 || fl_io_out[3:2] != 2'b11) io23_err++;
      if (mclk < 8) begin
        mcmd = {mcmd[6:0], fl_io_out[0]};
        if (mclk == 7) last_cmd = mcmd;
      end else if (mcmd == 8'hEB) begin
        if (mclk < 14) maddr = {maddr[19:0], fl_io_out};
      end else if (mclk < 32) begin
        maddr = {maddr[22:0], fl_io_out[0]};
      end
      mclk++;
    end
  end

  always @(negedge fl_sck) begin
    if (!fl_cs_n) begin
      int pre, w, k, per, c;
      logic [7:0] b;
      if (mcmd == 8'hEB)      begin pre = 20; w = 4; end
      else if (mcmd == 8'h3B) begin pre = 36; w = 2; end
      else                    begin pre = 40; w = 1; end
      if (mclk >= pre) begin
        k = mclk - pre;
        per = 8 / w;
        c = k % per;
        b = mem_byte(24'(maddr + 24'(k / per)));
        if (w == 1) begin m_drv[1] = b[7 - c]; m_oe = 4'b0010; end
        else if (w == 2) begin m_drv[1:0] = b[7 - 2*c -: 2]; m_oe = 4'b0011; end
        else begin m_drv = (c == 0) ? b[7:4] : b[3:0]; m_oe = 4'b1111; end
      end
    end
  end

  // ---------------- ready pattern ----------------
  logic [7:0] lfsr = 8'hA7;
  bit         rand_ready = 0;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready <= rand_ready ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // ---------------- monitor ----------------
  logic       prev_pend = 1'b0;
  logic [7:0] prev_d = '0;
  logic       prev_l = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((m_oe & fl_io_oe) != 4'b0000) clash_err++;
      if (!fl_cs_n && req_ready) busy_err++;
      if (prev_pend && (!rd_valid || rd_data != prev_d || rd_last != prev_l)) hold_err++;
      prev_pend = rd_valid && !rd_ready;
      prev_d = rd_data;
      prev_l = rd_last;
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected byte", 32'(rd_data), 32'h0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e[7:0], cur_tag, 32'(rd_data), 32'(e[7:0]));
          chk(rd_last == e[8], "R9 last flag", 32'(rd_last), 32'(e[8]));
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run_read(input logic [1:0] m, input logic [23:0] a, input logic [15:0] n,
                          input bit w, input logic [1:0] ws, input string tag);
    int t0, exp_tx;
    logic [23:0] cur, mask;
    logic [7:0] ecmd;
    t0 = txn_cnt;
    exp_tx = (n != 0) ? 1 : 0;
    mask = 24'((32'd8 << ws) - 32'd1);
    cur = a;
    for (int i = 0; i < int'(n); i++) begin
      exp_q.push_back({(i == int'(n) - 1), mem_byte(cur)});
      if (w && ((cur & mask) == mask) && (i < int'(n) - 1)) exp_tx++;
      cur = w ? ((cur & ~mask) | ((cur + 24'd1) & mask)) : cur + 24'd1;
    end
    ecmd = (m == 2'd1) ? 8'h3B : (m == 2'd2) ? 8'hEB : 8'h0B;
    cur_tag = tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_mode = m; req_addr = a; req_len = n; req_wrap = w; req_wsel = ws;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    while (exp_q.size() != 0 || !fl_cs_n || !req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(txn_cnt - t0 == exp_tx, {tag, " selections (R8/R10)"}, 32'(txn_cnt - t0), 32'(exp_tx));
    if (n != 0) chk(last_cmd == ecmd, {tag, " opcode"}, 32'(last_cmd), 32'(ecmd));
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fl_cs_n == 1'b1,   "R1 cs_n",     32'(fl_cs_n),  32'h1);
    chk(fl_sck == 1'b0,    "R1 sck",      32'(fl_sck),   32'h0);
    chk(fl_io_oe == 4'h0,  "R1 oe",       32'(fl_io_oe), 32'h0);
    chk(rd_valid == 1'b0,  "R1 rd_valid", 32'(rd_valid), 32'h0);
    chk(req_ready == 1'b1, "R1 req_ready",32'(req_ready),32'h1);

    run_read(2'd0, 24'h000100, 16'd5,  0, 2'd0, "R2 single data");
    run_read(2'd3, 24'h00A0F0, 16'd3,  0, 2'd0, "R2 mode3 as single");
    run_read(2'd1, 24'h12345E, 16'd6,  0, 2'd0, "R3 dual data");
    run_read(2'd2, 24'hABCDEF, 16'd9,  0, 2'd0, "R4 quad data");
    run_read(2'd2, 24'hFFFFFE, 16'd4,  0, 2'd0, "R7 linear rollover");
    run_read(2'd0, 16'd0 == 0 ? 24'h000300 : 24'h0, 16'd0, 0, 2'd0, "R10 empty request");
    chk(exp_q.size() == 0, "R10 no bytes", 32'(exp_q.size()), 32'h0);

    rand_ready = 1;
    run_read(2'd1, 24'h00200A, 16'd7,  0, 2'd0, "R9 dual under backpressure");
    run_read(2'd2, 24'h000105, 16'd10, 1, 2'd0, "R8 quad wrap8");
    run_read(2'd0, 24'h00002E, 16'd5,  1, 2'd1, "R8 single wrap16");
    run_read(2'd1, 24'h00053F, 16'd36, 1, 2'd2, "R8 dual wrap32");
    run_read(2'd2, 24'h000040, 16'd64, 1, 2'd3, "R8 quad wrap64 aligned");
    run_read(2'd2, 24'h00077E, 16'd70, 1, 2'd3, "R8 quad wrap64 two ends");
    rand_ready = 0;
    run_read(2'd0, 24'h0007FD, 16'd6,  1, 2'd0, "R8 single wrap8 full speed");

    chk(clash_err == 0, "R5 drive clash count", 32'(clash_err), 32'h0);
    chk(io23_err == 0,  "R6 IO2/IO3 level errors", 32'(io23_err), 32'h0);
    chk(hold_err == 0,  "R9 held byte changed", 32'(hold_err), 32'h0);
    chk(busy_err == 0,  "R11 ready while selected", 32'(busy_err), 32'h0);
    finish_run();
  end
endmodule